// File: doc/BRIEF.md
# Chip-Select Data Path Switch

This block sits between an 18-bit byte address, a small internal read-only array and an 8-bit bidirectional data port. Each byte fetch is announced by a one-cycle strobe. In that cycle the block compares the top four address bits with a chip identity that is fixed when the design is built. On a match it issues an internal read and, from the next cycle on, drives the fetched byte out of the data port. On a mismatch it holds the internal array idle, leaves the port as an input, and forwards the byte that external memory presents on the port.

The 18-bit space is split into sixteen regions of 16K bytes. The low 14 address bits select a byte inside a region. The internal array covers exactly one region. Its contents are a fixed pattern computed from the address, so a wide array never has to be stored in the model. The port direction is decided once per fetch and held until the next strobe. A power-down input overrides it and forces the port to high impedance.

Top module: `csel_data_switch`

## Requirements
- R1: After reset, port_oe is 0, byte_vld is 0, byte_out is 0x00 and port_out is 0x00.
- R2: rd_en is 1 during a cycle exactly when fetch_stb is 1, pwr_down is 0 and addr[17:14] equals the CHIP_ID parameter (default 4'h5). In every other cycle it is 0.
- R3: One cycle after a strobe with rd_en at 1, byte_out and port_out both equal the internal byte for addr[13:0], and port_oe is 1 while pwr_down stays 0. The internal byte for a 14-bit offset a is a[7:0] XOR {a[13:8], 2'b10}.
- R4: One cycle after a strobe with rd_en at 0, port_oe is 0 and byte_out equals the port_in value that was present in the strobe cycle.
- R5: Between strobes, and while pwr_down does not change, port_oe keeps its value. byte_out also keeps its value.
- R6: While pwr_down is 1, port_oe is 0, whatever was fetched last. A strobe taken while pwr_down is 1 is handled as a mismatch.
- R7: byte_vld is 1 in exactly the cycle that follows each strobe, and 0 in all other cycles.
- R8: port_out is 0x00 whenever port_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_down | input | 1 | Forces the port to input mode and blocks internal reads |
| fetch_stb | input | 1 | One-cycle pulse that starts a byte fetch |
| addr | input | 18 | Byte address of the fetch |
| port_in | input | 8 | Byte read from the bidirectional pads |
| port_out | output | 8 | Byte driven to the pads |
| port_oe | output | 1 | Pad output enable; 0 means input/high impedance |
| rd_en | output | 1 | Internal array read enable for the strobe cycle |
| byte_out | output | 8 | Selected byte for the serial path |
| byte_vld | output | 1 | byte_out carries a newly fetched byte |

## Verification
A stored direction bit that goes wrong appears on port_oe in the first cycle after the faulty strobe. It also swaps the source of byte_out, so the wrong byte shows up in that same cycle. A bad read enable or a bad array offset gives a wrong byte at the post-strobe sample, one cycle after the strobe. The idle cycles between strobes expose a direction or output that drifts without a strobe, and the power-down windows expose a pad that is driven when it should be quiet.

// File: rtl/csel_pkg.sv
package csel_pkg;
    localparam int ADDR_W  = 18;
    localparam int SEL_W   = 4;
    localparam int DATA_W  = 8;
    localparam int ROM_AW  = ADDR_W - SEL_W;
    localparam int MIX_W   = DATA_W - 2;

    function automatic logic [DATA_W-1:0] rom_pattern(input logic [ROM_AW-1:0] a);
        return a[DATA_W-1:0] ^ {a[ROM_AW-1 -: MIX_W], 2'b10};
    endfunction
endpackage

// File: rtl/csel_match.sv
module csel_match
    import csel_pkg::*;
#(
    parameter logic [SEL_W-1:0] CHIP_ID = 4'h5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_stb,
    input  logic             pwr_down,
    input  logic [SEL_W-1:0] addr_hi,
    output logic             hit,
    output logic             sel_q
);
    typedef struct packed {
        logic sel;
    } match_st_t;

    match_st_t st_d, st_q;

    always_comb begin
        hit    = (addr_hi == CHIP_ID) && !pwr_down;
        st_d   = st_q;
        if (fetch_stb) st_d.sel = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_q = st_q.sel;

    p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_stb |=> $stable(sel_q));
endmodule

// File: rtl/csel_rom.sv
module csel_rom
    import csel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ROM_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rom_st_t;

    rom_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en) st_d.data = rom_pattern(rd_addr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.data;

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/csel_capture.sv
module csel_capture
    import csel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_stb,
    input  logic [DATA_W-1:0] port_in,
    output logic [DATA_W-1:0] ext_data,
    output logic              vld
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vld;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = fetch_stb;
        if (fetch_stb) st_d.data = port_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ext_data = st_q.data;
    assign vld      = st_q.vld;

    p_vld_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stb |=> vld);
    p_vld_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_stb |=> !vld);
endmodule

// File: rtl/csel_data_switch.sv
module csel_data_switch
    import csel_pkg::*;
#(
    parameter logic [SEL_W-1:0] CHIP_ID = 4'h5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              fetch_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] port_in,
    output logic [DATA_W-1:0] port_out,
    output logic              port_oe,
    output logic              rd_en,
    output logic [DATA_W-1:0] byte_out,
    output logic              byte_vld
);
    logic              hit;
    logic              sel_q;
    logic [DATA_W-1:0] rom_data;
    logic [DATA_W-1:0] ext_data;

    csel_match #(.CHIP_ID(CHIP_ID)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_stb (fetch_stb),
        .pwr_down  (pwr_down),
        .addr_hi   (addr[ADDR_W-1 -: SEL_W]),
        .hit       (hit),
        .sel_q     (sel_q)
    );

    csel_rom u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (addr[ROM_AW-1:0]),
        .rd_data (rom_data)
    );

    csel_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_stb (fetch_stb),
        .port_in   (port_in),
        .ext_data  (ext_data),
        .vld       (byte_vld)
    );

    always_comb begin
        rd_en    = fetch_stb && hit;
        port_oe  = sel_q && !pwr_down;
        byte_out = sel_q ? rom_data : ext_data;
        port_out = port_oe ? rom_data : '0;
    end

    p_rd_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (fetch_stb && !pwr_down));
    p_hit_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (pwr_down || port_oe));
    p_miss_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stb && !rd_en) |=> !port_oe);
    p_oe_off_pd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !port_oe);
    p_out_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !port_oe |-> (port_out == '0));
endmodule

// File: tb/csel_data_switch_tb.sv
module csel_data_switch_tb;
    import csel_pkg::*;

    localparam logic [3:0] ID = 4'h5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_down = 1'b0;
    logic        fetch_stb = 1'b0;
    logic [17:0] addr = '0;
    logic [7:0]  port_in = '0;
    logic [7:0]  port_out;
    logic        port_oe;
    logic        rd_en;
    logic [7:0]  byte_out;
    logic        byte_vld;

    int n_cmp = 0;
    int n_bad = 0;
    logic       exp_sel = 1'b0;
    logic [7:0] exp_byte = 8'h00;

    csel_data_switch #(.CHIP_ID(ID)) u_dut (
        .clk, .rst_n, .pwr_down, .fetch_stb, .addr, .port_in,
        .port_out, .port_oe, .rd_en, .byte_out, .byte_vld
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] exp_rom(input logic [13:0] a);
        return a[7:0] ^ {a[13:8], 2'b10};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(port_oe == (exp_sel && !pwr_down), {req, " oe"}, port_oe, exp_sel && !pwr_down);
        check(byte_out == exp_byte, {req, " byte"}, byte_out, exp_byte);
        check(byte_vld == 1'b0, "R7 vld idle", byte_vld, 0);
        check(rd_en == 1'b0, "R2 rd idle", rd_en, 0);
        check(port_oe || port_out == 8'h00, "R8 out quiet", port_out, 0);
    endtask

    task automatic fetch(input logic [17:0] a, input logic [7:0] pin);
        logic h;
        @(negedge clk);
        addr = a; port_in = pin; fetch_stb = 1'b1;
        #1;
        h = (a[17:14] == ID) && !pwr_down;
        check(rd_en == h, "R2 rd_en", rd_en, h);
        @(negedge clk);
        fetch_stb = 1'b0;
        port_in = ~pin;
        exp_sel = h;
        exp_byte = h ? exp_rom(a[13:0]) : pin;
        check(byte_vld == 1'b1, "R7 vld", byte_vld, 1);
        if (h) begin
            check(byte_out == exp_byte, "R3 byte", byte_out, exp_byte);
            check(port_out == exp_byte, "R3 port_out", port_out, exp_byte);
            check(port_oe == 1'b1, "R3 oe", port_oe, 1);
        end else begin
            check(byte_out == exp_byte, "R4 byte", byte_out, exp_byte);
            check(port_oe == 1'b0, "R4/R6 oe", port_oe, 0);
            check(port_out == 8'h00, "R8 out quiet", port_out, 0);
        end
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        #2;
        check(port_oe == 0 && byte_vld == 0, "R1 ctrl", {port_oe, byte_vld}, 0);
        check(byte_out == 0 && port_out == 0, "R1 data", byte_out, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(port_oe == 0 && byte_out == 0 && byte_vld == 0, "R1 after release", byte_out, 0);
        check(rd_en == 0, "R2 no strobe", rd_en, 0);

        // directed corners
        fetch({ID, 14'h0000}, 8'hAA);
        fetch({ID, 14'h3FFF}, 8'h11);
        @(negedge clk); check_idle("R5 hold after hit");
        fetch({4'h4, 14'h3FFF}, 8'h5A);
        @(negedge clk); check_idle("R5 hold after miss");
        fetch({4'h6, 14'h0000}, 8'hC3);
        fetch({ID, 14'h2A55}, 8'h00);
        pwr_down = 1'b1;
        @(negedge clk);
        check(port_oe == 0, "R6 oe in pd", port_oe, 0);
        check(port_out == 0, "R8 out in pd", port_out, 0);
        fetch({ID, 14'h1234}, 8'h77);  // strobe in power-down is a miss
        pwr_down = 1'b0;
        @(negedge clk); check_idle("R6 after pd");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [17:0] a;
            a = 18'($urandom);
            if ($urandom_range(1, 0) == 1) a[17:14] = ID;
            if ($urandom_range(9, 0) == 0) begin
                @(negedge clk);
                pwr_down = ~pwr_down;
                #1 check_idle("R6 pd toggle");
            end
            fetch(a, 8'($urandom));
            for (int k = 0; k < int'($urandom_range(2, 0)); k++) begin
                @(negedge clk);
                check_idle("R5 idle");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule